// File: doc/BRIEF.md
# Serial Register Access Slave

This block is a four-wire serial slave that turns fixed-length frames from an external master into accesses on a simple parallel register bus. A frame opens when chip select goes low and closes when it returns high. Inside the frame, the block samples the data-in line on each rising serial clock edge. The first eight bits form an instruction: a read/write bit, a streaming flag, a register address and two reserved bits. The remaining sixteen bits are either the value to store or the window in which the read value is shifted out.

All serial inputs pass through a synchronizer into the system clock domain, and every decision is made there. The serial clock half-period must therefore span at least six system clock cycles. A read request goes to the register bus as soon as the instruction byte is complete. The bus answers one cycle later, and the block then shifts the value out most significant bit first. A 2-bit phase input chooses whether the output changes on falling or on rising serial clock edges. A write strobe is issued only when a full frame has arrived. A frame cut short by chip select is dropped.

Top module: `sreg_spi_slave`

## Requirements
- R1: Data-in is sampled on rising SCLK edges while cs_n is low. Only the first 24 rising edges of a frame count. cs_n going high returns the count to zero.
- R2: Frame bit 23, the first bit sent, selects the access type: 0 is a write and 1 is a read. A write frame never raises reg_re, and a read frame never raises reg_we.
- R3: Frame bits 21..18 are the register address, most significant bit first, and appear on reg_addr during the access strobe.
- R4: A write frame raises reg_we for exactly one clk cycle after its 24th rising edge. reg_wdata then carries frame bits 15..0, sent most significant bit first.
- R5: A frame in which cs_n rises before the 24th rising edge produces no write strobe and leaves the register contents unchanged.
- R6: A read frame raises reg_re for exactly one clk cycle after its 8th rising edge. reg_rdata is taken on the following clk cycle.
- R7: sdo is 0 during the instruction byte, for the whole of a write frame, whenever cs_n is high, and after reset.
- R8: With phase_sel = 01, sdo changes on falling SCLK edges. It presents D15 from the falling edge after the 8th rising edge and D0 from the falling edge after the 23rd.
- R9: With phase_sel = 10, 00 or 11, sdo changes on rising SCLK edges. It presents D15 from the 9th rising edge and D0 from the 24th.
- R10: The streaming flag (bit 22) and the reserved bits (17..16) do not alter the access. The frame acts as a single access to the decoded address.
- R11: Rising SCLK edges beyond the 24th in the same frame are ignored: no second strobe and no change to the stored value.
- R12: Data-in bits sent during the data field of a read frame are ignored and cause no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Frame select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| phase_sel | input | 2 | Output edge select: 01 falling, otherwise rising |
| reg_addr | output | ADDR_W | Register address for the current access |
| reg_wdata | output | DATA_W | Write value |
| reg_we | output | 1 | One-cycle write strobe |
| reg_re | output | 1 | One-cycle read request |
| reg_rdata | input | DATA_W | Read value, valid the cycle after reg_re |

## Verification
The checker watches several rules on every cycle:
- a write strobe appears only with a full bit count and in a write frame;
- a read request appears only in a read frame, right after the instruction byte, and for a single cycle;
- the bit count never passes 24;
- sdo stays low while the instruction byte is still arriving.

Other behaviour can only be shown by the bench scenarios:
- the bit-exact order of read data on each edge choice, and the half-cycle shift between the two phase modes;
- short frames leaving stored values unchanged;
- extra clocks and ignored streaming or reserved bits;
- read-data-field input having no effect.

// File: rtl/sreg_pkg.sv
// Shared definitions for the serial register slave.
// Assumes: the instruction byte is eight bits wide whatever the data width.
package sreg_pkg;

    localparam int INSTR_BITS = 8;

    // Output edge choice as coded on phase_sel.
    typedef enum logic [1:0] {
        PH_RISE_00 = 2'b00,
        PH_FALL    = 2'b01,
        PH_RISE    = 2'b10,
        PH_RISE_11 = 2'b11
    } sdo_phase_e;

    // True when the output must change on falling serial clock edges.
    function automatic logic phase_on_fall(input logic [1:0] ph);
        return sdo_phase_e'(ph) == PH_FALL;
    endfunction

endpackage

// File: rtl/sreg_sync_edge.sv
// Brings sclk, cs_n and sdi into the clk domain and flags serial clock edges.
// Assumes: STAGES >= 2 and sclk half-period well above STAGES+2 clk cycles.
module sreg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic sdi_s
);

    logic [STAGES-1:0] sclk_p;
    logic [STAGES-1:0] cs_p;
    logic [STAGES-1:0] sdi_p;
    logic              sclk_d;
    logic              sclk_s;

    // Synchronizer chains; cs idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_p <= '0;
            cs_p   <= '1;
            sdi_p  <= '0;
        end else begin
            sclk_p <= {sclk_p[STAGES-2:0], sclk};
            cs_p   <= {cs_p[STAGES-2:0], cs_n};
            sdi_p  <= {sdi_p[STAGES-2:0], sdi};
        end
    end

    // Previous synchronized sclk for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign sclk_s    = sclk_p[STAGES-1];
    assign sclk_rise = sclk_s & ~sclk_d;
    assign sclk_fall = ~sclk_s & sclk_d;
    assign cs_act    = ~cs_p[STAGES-1];
    assign sdi_s     = sdi_p[STAGES-1];

endmodule

// File: rtl/sreg_frame_rx.sv
// Counts frame bits, decodes the instruction byte and issues bus strobes.
// Assumes: inputs already synchronized; one sample per sclk_rise.
module sreg_frame_rx
    import sreg_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cs_act,
    input  logic                           sclk_rise,
    input  logic                           sdi_s,
    output logic [$clog2(INSTR_BITS+DATA_W+1)-1:0] bit_cnt,
    output logic                           rd_active,
    output logic [ADDR_W-1:0]              reg_addr,
    output logic [DATA_W-1:0]              reg_wdata,
    output logic                           reg_we,
    output logic                           reg_re
);

    localparam int FRAME_W  = INSTR_BITS + DATA_W;
    localparam int CNT_W    = $clog2(FRAME_W + 1);
    localparam int ADDR_TOP = INSTR_BITS - 3;

    logic [DATA_W-2:0] sh;
    logic [DATA_W-1:0] nxt;
    logic              take;
    logic              instr_done;
    logic              frame_done;

    assign take       = cs_act & sclk_rise & (bit_cnt < CNT_W'(FRAME_W));
    assign nxt        = {sh, sdi_s};
    assign instr_done = take & (bit_cnt == CNT_W'(INSTR_BITS - 1));
    assign frame_done = take & (bit_cnt == CNT_W'(FRAME_W - 1));

    // Bit counter: cleared while idle, saturates at a full frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       bit_cnt <= '0;
        else if (!cs_act) bit_cnt <= '0;
        else if (take)    bit_cnt <= bit_cnt + 1'b1;
    end

    // Input shift register.
    always_ff @(posedge clk) begin
        if (!rst_n)    sh <= '0;
        else if (take) sh <= nxt[DATA_W-2:0];
    end

    // Instruction decode; streaming flag and reserved bits are not used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_active <= 1'b0;
            reg_addr  <= '0;
        end else if (!cs_act) begin
            rd_active <= 1'b0;
        end else if (instr_done) begin
            rd_active <= nxt[INSTR_BITS-1];
            reg_addr  <= nxt[ADDR_TOP -: ADDR_W];
        end
    end

    // Read request right after the instruction byte.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_re <= 1'b0;
        else        reg_re <= instr_done & nxt[INSTR_BITS-1];
    end

    // Write strobe and data after the last frame bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= frame_done & ~rd_active;
            if (frame_done & ~rd_active) reg_wdata <= nxt;
        end
    end

endmodule

// File: rtl/sreg_sdo_tx.sv
// Loads read data one cycle after the request and shifts it out MSB first
// on the serial clock edge chosen by phase_sel (latched at load).
// Assumes: read data valid on the clk cycle after rd_req.
module sreg_sdo_tx
    import sreg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              rd_active,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              rd_req,
    input  logic [DATA_W-1:0] rdata,
    input  logic [1:0]        phase_sel,
    output logic              sdo_q
);

    localparam int LEFT_W = $clog2(DATA_W + 1);

    logic              load;
    logic [DATA_W-1:0] sh;
    logic [LEFT_W-1:0] left;
    logic              on_fall;
    logic              out_edge;

    assign out_edge = on_fall ? sclk_fall : sclk_rise;

    // Delay the request by one cycle to meet the bus read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) load <= 1'b0;
        else        load <= rd_req;
    end

    // Output shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            left    <= '0;
            on_fall <= 1'b0;
            sdo_q   <= 1'b0;
        end else if (!cs_act || !rd_active) begin
            left  <= '0;
            sdo_q <= 1'b0;
        end else if (load) begin
            sh      <= rdata;
            left    <= LEFT_W'(DATA_W);
            on_fall <= phase_on_fall(phase_sel);
        end else if ((left != '0) && out_edge) begin
            sdo_q <= sh[DATA_W-1];
            sh    <= {sh[DATA_W-2:0], 1'b0};
            left  <= left - 1'b1;
        end
    end

endmodule

// File: rtl/sreg_spi_slave.sv
// Top of the serial register slave: synchronizer, frame receiver and
// read-data transmitter. Assumes sclk half-period >= 6 clk cycles and
// cs_n high for >= 4 clk cycles between frames.
module sreg_spi_slave
    import sreg_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              sdi,
    output logic              sdo,
    input  logic [1:0]        phase_sel,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [DATA_W-1:0] reg_rdata
);

    localparam int FRAME_W = INSTR_BITS + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic             sclk_rise;
    logic             sclk_fall;
    logic             cs_act;
    logic             sdi_s;
    logic [CNT_W-1:0] bit_cnt;
    logic             rd_active;
    logic             sdo_q;

    sreg_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_act    (cs_act),
        .sdi_s     (sdi_s)
    );

    sreg_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sdi_s     (sdi_s),
        .bit_cnt   (bit_cnt),
        .rd_active (rd_active),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re)
    );

    sreg_sdo_tx #(.DATA_W(DATA_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .rd_active (rd_active),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .rd_req    (reg_re),
        .rdata     (reg_rdata),
        .phase_sel (phase_sel),
        .sdo_q     (sdo_q)
    );

    // Output forced low at once whenever the frame select is released.
    assign sdo = sdo_q & ~cs_n;

endmodule

// File: rtl/sreg_spi_slave_chk.sv
// Cycle-level rules for the serial register slave, bound into the top.
module sreg_spi_slave_chk #(
    parameter int DATA_W = 16
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                sdo,
    input logic                                reg_we,
    input logic                                reg_re,
    input logic                                rd_active,
    input logic [$clog2(8+DATA_W+1)-1:0]       bit_cnt
);

    localparam int FRAME_W = 8 + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    // R4: write strobe only once the full frame has been counted
    a_r4_we_full_frame: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> bit_cnt == CNT_W'(FRAME_W));

    // R2: write strobe never in a read frame
    a_r2_we_not_read: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !rd_active);

    // R6: read request only in a read frame, right after the instruction byte
    a_r6_re_after_instr: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> (rd_active && bit_cnt == CNT_W'(8)));

    // R6: read request lasts a single cycle
    a_r6_re_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R11: write strobe lasts a single cycle
    a_r11_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R1: count never passes a full frame
    a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_W));

    // R7: output low while the instruction byte is arriving
    a_r7_sdo_instr_low: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cnt < CNT_W'(8)) |-> !sdo);

endmodule

bind sreg_spi_slave sreg_spi_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sdo       (sdo),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .rd_active (rd_active),
    .bit_cnt   (bit_cnt)
);

// File: tb/sreg_spi_slave_tb.sv
module sreg_spi_slave_tb;

    localparam int HALF = 8;   // clk cycles per sclk half-period
    localparam int NVEC = 10;

    // {instr[7:0], data[15:0], phase[1:0], nbits[4:0], extra[2:0]}
    // instr = {rw, stream, addr[3:0], rsvd[1:0]}
    localparam logic [33:0] VEC [NVEC] = '{
        {8'h0C, 16'hA5C3, 2'b10, 5'd24, 3'd0},  // write a3
        {8'h8C, 16'h0000, 2'b10, 5'd24, 3'd0},  // read a3, rising
        {8'h8C, 16'h0000, 2'b01, 5'd24, 3'd0},  // read a3, falling
        {8'h7F, 16'h1234, 2'b00, 5'd24, 3'd0},  // write aF, S=1 rsvd=11
        {8'hBC, 16'h0000, 2'b11, 5'd24, 3'd0},  // read aF, phase 11
        {8'h0C, 16'hFFFF, 2'b10, 5'd20, 3'd0},  // short write a3
        {8'h8C, 16'h0000, 2'b01, 5'd24, 3'd0},  // read a3 again
        {8'h00, 16'h8001, 2'b10, 5'd24, 3'd4},  // write a0 with extra clocks
        {8'h80, 16'hFFFF, 2'b10, 5'd24, 3'd0},  // read a0, sdi ones in data
        {8'hC0, 16'h0000, 2'b01, 5'd24, 3'd0}   // read a0, S=1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [1:0]  phase_sel = 2'b10;
    logic [3:0]  reg_addr;
    logic [15:0] reg_wdata;
    logic        reg_we;
    logic        reg_re;
    logic [15:0] reg_rdata;

    logic [15:0] bank [16];
    int          we_tot;
    int          re_tot;
    logic [3:0]  last_addr;
    logic [15:0] last_wd;

    int errors = 0;
    int checks = 0;
    logic [15:0] exp_mem [16];
    logic [23:0] smp_r;
    logic [23:0] smp_f;

    always #2 clk = ~clk;

    sreg_spi_slave u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .sdo       (sdo),
        .phase_sel (phase_sel),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_rdata (reg_rdata)
    );

    // Register bank model with one-cycle read latency, plus strobe logging.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) bank[i] <= '0;
            reg_rdata <= '0;
            we_tot    <= 0;
            re_tot    <= 0;
            last_addr <= '0;
            last_wd   <= '0;
        end else begin
            if (reg_we) begin
                bank[reg_addr] <= reg_wdata;
                we_tot    <= we_tot + 1;
                last_addr <= reg_addr;
                last_wd   <= reg_wdata;
            end
            if (reg_re) begin
                reg_rdata <= bank[reg_addr];
                re_tot    <= re_tot + 1;
                last_addr <= reg_addr;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one frame of nbits+extra serial clocks, sampling sdo before each edge.
    task automatic send(input logic [23:0] f, input int nbits, input int extra);
        smp_r = '0;
        smp_f = '0;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits + extra; i++) begin
            sclk = 1'b0;
            sdi  = (i < 24) ? f[23 - i] : 1'b1;
            repeat (HALF - 1) @(negedge clk);
            if (i < 24) smp_r[23 - i] = sdo;
            @(negedge clk);
            sclk = 1'b1;
            repeat (HALF - 1) @(negedge clk);
            if (i < 24) smp_f[23 - i] = sdo;
            @(negedge clk);
        end
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        sdi  = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        for (int i = 0; i < 16; i++) exp_mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R7: reset state
        check("R7 reset sdo", 32'(sdo), 32'h0);
        check("R7 reset strobes", {30'h0, reg_we, reg_re}, 32'h0);

        for (int v = 0; v < NVEC; v++) begin
            logic [7:0]  ins;
            logic [15:0] dat;
            logic [1:0]  ph;
            int          nb;
            int          ex;
            int          we0;
            int          re0;
            logic        rd;
            logic [3:0]  ad;
            ins = VEC[v][33:26];
            dat = VEC[v][25:10];
            ph  = VEC[v][9:8];
            nb  = int'(VEC[v][7:3]);
            ex  = int'(VEC[v][2:0]);
            rd  = ins[7];
            ad  = ins[5:2];
            phase_sel = ph;
            we0 = we_tot;
            re0 = re_tot;
            send({ins, dat}, nb, ex);
            if (!rd) begin
                // R4 R5 R11: exactly one strobe for a full frame, none for short
                check("R4/R5/R11 write strobe count", 32'(we_tot - we0), (nb == 24) ? 32'd1 : 32'd0);
                check("R2 no read on write frame", 32'(re_tot - re0), 32'd0);
                check("R7 sdo low in write frame", {smp_r[23:8], smp_f[23:8]}, 32'h0);
                if (nb == 24) begin
                    exp_mem[ad] = dat;
                    // R3 R10: address decoded regardless of S and reserved bits
                    check("R3/R10 write address", 32'(last_addr), 32'(ad));
                    check("R4 write data", 32'(last_wd), 32'(dat));
                end
            end else begin
                check("R6 one read request", 32'(re_tot - re0), 32'd1);
                check("R12 no write in read frame", 32'(we_tot - we0), 32'd0);
                check("R3 read address", 32'(last_addr), 32'(ad));
                check("R7 sdo low in instruction", {24'h0, smp_r[23:16] | smp_f[23:16]}, 32'h0);
                if (ph == 2'b01) begin
                    // R8: data present before each rising edge 9..24
                    check("R8 falling-edge data", 32'(smp_r[15:0]), 32'(exp_mem[ad]));
                    check("R8 data held to next fall", 32'(smp_f[15:0]), 32'(exp_mem[ad]));
                end else begin
                    // R9: D15 appears only after rising edge 9
                    check("R9 rising-edge data", 32'(smp_f[15:0]), 32'(exp_mem[ad]));
                    check("R9 half-cycle lag", 32'(smp_r[15:0]), 32'({1'b0, exp_mem[ad][15:1]}));
                end
            end
        end

        // R5/R7: read aborted mid-data, sdo drops when cs_n rises, no write
        begin
            int we0;
            int re0;
            we0 = we_tot;
            re0 = re_tot;
            phase_sel = 2'b01;
            send({8'h8C, 16'h0000}, 14, 0);
            check("R7 sdo low after abort", 32'(sdo), 32'h0);
            check("R5 no write on aborted frame", 32'(we_tot - we0), 32'd0);
            check("R6 read issued on aborted frame", 32'(re_tot - re0), 32'd1);
        end

        // R1: a 7-bit frame sends no request and the next frame decodes cleanly
        begin
            int re0;
            re0 = re_tot;
            send({8'h8C, 16'h0000}, 7, 0);
            check("R1 count cleared by cs_n", 32'(re_tot - re0), 32'd0);
            phase_sel = 2'b10;
            send({8'h8C, 16'h0000}, 24, 0);
            check("R1 frame after short frame", 32'(smp_f[15:0]), 32'(exp_mem[3]));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule